// File: doc/BRIEF.md
# Quad I/O Continuous Read Controller

This block is the host side of a read-only path to a serial NOR flash that has four data lines. A client issues word read requests on a simple valid/ready bus. Each request becomes one quad I/O fast-read transaction on the flash pins: a chip select, a serial clock, and four data lanes, each with its own output enable. The block packs the returned nibbles into a data word and returns it with a one-cycle response strobe.

The controller keeps track of whether the flash is in its command-less continuous-read state. After the flash has accepted a mode byte that keeps this state, every later transaction leaves out the 8-clock opcode and starts with the address. A single-cycle exit input makes the next transaction send an all-ones mode byte. That byte takes the flash out of continuous reading, so the transaction after it carries the opcode again. The serial clock is the system clock divided by an even parameter. Serial clock mode 0 is used: outputs change on falling edges, and both sides sample on rising edges.

Top module: `qxr_reader`

## Requirements
- R1: After reset, flash_cs_n is high, flash_sclk is low, flash_io_oe is 0, req_ready is high and rsp_valid is low. The continuous-read flag is clear, so the first transaction carries the opcode.
- R2: When the continuous-read flag is clear, a transaction starts with opcode EBh. The opcode is sent on lane 0 only (flash_io_oe = 0001b), one bit per serial clock, most significant bit first, over 8 clocks.
- R3: The 24-bit address follows. It is sent on all four lanes (flash_io_oe = 1111b), lane 3 carrying the highest bit of each nibble, most significant nibble first, over 6 clocks.
- R4: A 2-clock mode byte follows the address on all four lanes. Its value is 20h (bits 5..4 = 10b) unless an exit is pending, in which case it is FFh.
- R5: A transaction whose mode byte has bits 5..4 = 10b sets the flag. The next transaction then starts directly with the address and has 20 serial clocks in total instead of 28.
- R6: A pulse on exit_req makes the next accepted transaction send FFh as its mode byte and clears the flag. The transaction after that carries the opcode again.
- R7: Four dummy clocks follow the mode byte. All four output enables are 0 from the first dummy clock until chip select rises.
- R8: Eight data nibbles are sampled on rising serial clock edges. The first nibble goes to rsp_data[31:28]. rsp_valid is a one-cycle pulse in the cycle in which chip select rises.
- R9: The serial clock period is CLK_DIV system cycles. rsp_valid rises exactly (serial clocks of the transaction) x CLK_DIV cycles after the edge that accepts the request.
- R10: While chip select is high, flash_sclk is low and all output enables are 0. Chip select stays high for at least CLK_DIV system cycles between transactions.
- R11: req_ready is high only while the block is idle with chip select high. A request is accepted only when req_valid and req_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller idle, can accept a request |
| req_addr | input | 24 | Byte address of the word to read |
| exit_req | input | 1 | Pulse: leave continuous-read mode on the next transaction |
| rsp_valid | output | 1 | One-cycle strobe, rsp_data is valid |
| rsp_data | output | 32 | Read word, first nibble in the top bits |
| flash_sclk | output | 1 | Serial clock to the flash |
| flash_cs_n | output | 1 | Active-low chip select |
| flash_io_o | output | 4 | Data lanes driven toward the flash |
| flash_io_oe | output | 4 | Per-lane output enable |
| flash_io_i | input | 4 | Data lanes driven by the flash |

## Verification
The response is due exactly 28 x CLK_DIV system cycles after the accepting edge when the opcode is sent, and 20 x CLK_DIV cycles when it is skipped. Chip select rises on that same edge. The bench counts falling system-clock edges from the one that follows acceptance and requires the strobe at exactly that count. Lane values and enables are recorded at the first falling system edge after each serial clock rise, so each recorded nibble is the value the flash samples. The flash model drives each data nibble after the serial falling edge that precedes the clock on which the controller samples it.

// File: rtl/qxr_pkg.sv
package qxr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA,
        PH_GAP
    } phase_e;

    localparam logic [7:0] OPCODE_QREAD = 8'hEB;
    localparam int CMD_CLKS   = 8;
    localparam int ADDR_CLKS  = 6;
    localparam int MODE_CLKS  = 2;
    localparam int DUMMY_CLKS = 4;
    localparam int ADDR_W     = 24;

endpackage

// File: rtl/qxr_divider.sv
module qxr_divider #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(HALF - 1));
        cnt_d = cnt_q + CW'(1);
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/qxr_lane_mux.sv
module qxr_lane_mux (
    input  qxr_pkg::phase_e ph,
    input  logic [31:0]     sh,
    output logic [3:0]      io_o
);
    for (genvar l = 0; l < 4; l++) begin : g_lane
        if (l == 0) begin : g_io0
            // lane 0 carries the serial opcode bit, otherwise a nibble bit
            assign io_o[l] = (ph == qxr_pkg::PH_CMD) ? sh[31] : sh[28 + l];
        end else begin : g_ioq
            assign io_o[l] = (ph == qxr_pkg::PH_CMD) ? 1'b0 : sh[28 + l];
        end
    end
endmodule

// File: rtl/qxr_engine.sv
module qxr_engine #(
    parameter int         WORD_W    = 32,
    parameter logic [7:0] MODE_KEEP = 8'h20,
    parameter logic [7:0] MODE_EXIT = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    output logic                  run,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [23:0]           req_addr,
    input  logic                  exit_req,
    output logic                  rsp_valid,
    output logic [WORD_W-1:0]     rsp_data,
    output logic                  sclk,
    output logic                  cs_n,
    output logic [3:0]            io_oe,
    input  logic [3:0]            io_i,
    output qxr_pkg::phase_e       ph,
    output logic [31:0]           sh
);
    import qxr_pkg::*;

    localparam int NIB    = WORD_W / 4;
    localparam int MAXLEN = (NIB > CMD_CLKS) ? NIB : CMD_CLKS;
    localparam int CNT_W  = $clog2(MAXLEN) + 1;

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic               sclk;
        logic               cs_n;
        logic [3:0]         oe;
        logic [31:0]        sh;
        logic [31:0]        hold;
        logic               cont;
        logic               exit_pend;
        logic [WORD_W-1:0]  word;
        logic               rsp;
    } ctl_t;

    ctl_t d, q;
    logic [7:0]       mbyte;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        case (q.ph)
            PH_CMD:   last_cnt = CNT_W'(CMD_CLKS - 1);
            PH_ADDR:  last_cnt = CNT_W'(ADDR_CLKS - 1);
            PH_MODE:  last_cnt = CNT_W'(MODE_CLKS - 1);
            PH_DUMMY: last_cnt = CNT_W'(DUMMY_CLKS - 1);
            PH_DATA:  last_cnt = CNT_W'(NIB - 1);
            default:  last_cnt = '0;
        endcase
    end

    always_comb begin
        d     = q;
        d.rsp = 1'b0;
        mbyte = (q.exit_pend || exit_req) ? MODE_EXIT : MODE_KEEP;
        if (exit_req) begin
            d.exit_pend = 1'b1;
        end

        case (q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    d.hold      = {req_addr, mbyte};
                    d.cs_n      = 1'b0;
                    d.sclk      = 1'b0;
                    d.cnt       = '0;
                    d.word      = '0;
                    d.exit_pend = 1'b0;
                    d.cont      = (mbyte[5:4] == 2'b10);
                    if (q.cont) begin
                        d.ph = PH_ADDR;
                        d.sh = {req_addr, mbyte};
                        d.oe = 4'b1111;
                    end else begin
                        d.ph = PH_CMD;
                        d.sh = {OPCODE_QREAD, 24'h0};
                        d.oe = 4'b0001;
                    end
                end
            end

            PH_GAP: begin
                if (tick) begin
                    if (q.cnt == CNT_W'(1)) begin
                        d.ph  = PH_IDLE;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end

            default: begin
                if (tick && !q.sclk) begin
                    // rising serial edge: flash samples host lanes, host samples data
                    d.sclk = 1'b1;
                    if (q.ph == PH_DATA) begin
                        d.word = {q.word[WORD_W-5:0], io_i};
                    end
                end else if (tick) begin
                    // falling serial edge: advance the outgoing stream
                    d.sclk = 1'b0;
                    d.sh   = (q.ph == PH_CMD) ? {q.sh[30:0], 1'b0}
                                              : {q.sh[27:0], 4'h0};
                    if (q.cnt == last_cnt) begin
                        d.cnt = '0;
                        case (q.ph)
                            PH_CMD: begin
                                d.ph = PH_ADDR;
                                d.sh = q.hold;
                                d.oe = 4'b1111;
                            end
                            PH_ADDR:  d.ph = PH_MODE;
                            PH_MODE: begin
                                d.ph = PH_DUMMY;
                                d.oe = 4'b0000;
                            end
                            PH_DUMMY: d.ph = PH_DATA;
                            default: begin
                                d.ph   = PH_GAP;
                                d.cs_n = 1'b1;
                                d.rsp  = 1'b1;
                            end
                        endcase
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph        <= PH_IDLE;
            q.cnt       <= '0;
            q.sclk      <= 1'b0;
            q.cs_n      <= 1'b1;
            q.oe        <= 4'b0000;
            q.sh        <= '0;
            q.hold      <= '0;
            q.cont      <= 1'b0;
            q.exit_pend <= 1'b0;
            q.word      <= '0;
            q.rsp       <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign run       = (q.ph != PH_IDLE);
    assign req_ready = (q.ph == PH_IDLE);
    assign rsp_valid = q.rsp;
    assign rsp_data  = q.word;
    assign sclk      = q.sclk;
    assign cs_n      = q.cs_n;
    assign io_oe     = q.oe;
    assign ph        = q.ph;
    assign sh        = q.sh;
endmodule

// File: rtl/qxr_reader.sv
module qxr_reader #(
    parameter int         CLK_DIV   = 4,
    parameter int         WORD_W    = 32,
    parameter logic [7:0] MODE_KEEP = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [23:0]       req_addr,
    input  logic              exit_req,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              flash_sclk,
    output logic              flash_cs_n,
    output logic [3:0]        flash_io_o,
    output logic [3:0]        flash_io_oe,
    input  logic [3:0]        flash_io_i
);
    localparam int HALF = CLK_DIV / 2;

    logic            tick;
    logic            run;
    qxr_pkg::phase_e ph;
    logic [31:0]     sh;

    qxr_divider #(.HALF(HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    qxr_engine #(
        .WORD_W    (WORD_W),
        .MODE_KEEP (MODE_KEEP),
        .MODE_EXIT (8'hFF)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (run),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .exit_req  (exit_req),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .sclk      (flash_sclk),
        .cs_n      (flash_cs_n),
        .io_oe     (flash_io_oe),
        .io_i      (flash_io_i),
        .ph        (ph),
        .sh        (sh)
    );

    qxr_lane_mux u_mux (
        .ph   (ph),
        .sh   (sh),
        .io_o (flash_io_o)
    );
endmodule

// File: rtl/qxr_reader_chk.sv
module qxr_reader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       flash_sclk,
    input logic       flash_cs_n,
    input logic [3:0] flash_io_o,
    input logic [3:0] flash_io_oe
);
    p_quiet_when_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs_n |-> (!flash_sclk && flash_io_oe == 4'b0000));

    p_cs_high_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_cs_n) |=> flash_cs_n);

    p_rsp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rsp_at_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(flash_cs_n));

    p_ready_only_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> flash_cs_n);

    p_oe_pattern_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_io_oe == 4'b0000) || (flash_io_oe == 4'b0001) || (flash_io_oe == 4'b1111));

    p_lanes_steady_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_cs_n && flash_sclk && $past(flash_sclk)) |-> $stable(flash_io_o));
endmodule

bind qxr_reader qxr_reader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .flash_sclk  (flash_sclk),
    .flash_cs_n  (flash_cs_n),
    .flash_io_o  (flash_io_o),
    .flash_io_oe (flash_io_oe)
);

// File: tb/qxr_reader_tb.sv
`timescale 1ns/1ps
module qxr_reader_tb;
    localparam int CLK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        exit_req = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        flash_sclk, flash_cs_n;
    logic [3:0]  flash_io_o, flash_io_oe;
    logic [3:0]  flash_io_i = 4'h0;

    int n_checks = 0;
    int n_err = 0;
    bit exp_cont = 1'b0;

    always #2.5 clk = ~clk;

    qxr_reader #(.CLK_DIV(CLK_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .exit_req(exit_req), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .flash_sclk(flash_sclk), .flash_cs_n(flash_cs_n),
        .flash_io_o(flash_io_o), .flash_io_oe(flash_io_oe), .flash_io_i(flash_io_i)
    );

    // flash-side model and monitor, all on falling system edges
    logic [3:0]  cap_o  [0:39];
    logic [3:0]  cap_oe [0:39];
    int          rc = 0;
    int          data_start = 20;
    logic [31:0] flash_word = '0;
    logic        prev_sclk = 1'b0, prev_cs = 1'b1;
    int          gap_cnt = 0, last_gap = 0;
    int          since_rise = 0, period_bad = 0;

    always @(negedge clk) begin
        if (!flash_cs_n && prev_cs) begin
            rc = 0;
            last_gap = gap_cnt;
            gap_cnt = 0;
        end
        if (flash_cs_n) gap_cnt++;
        since_rise++;
        if (!flash_cs_n && flash_sclk && !prev_sclk) begin
            if (rc > 0 && since_rise != CLK_DIV) period_bad++;
            since_rise = 0;
            if (rc < 40) begin
                cap_o[rc]  = flash_io_o;
                cap_oe[rc] = flash_io_oe;
            end
            rc++;
        end
        if (!flash_cs_n && !flash_sclk && prev_sclk) begin
            if (rc >= data_start && rc - data_start < 8)
                flash_io_i = flash_word[(31 - 4*(rc - data_start)) -: 4];
        end
        prev_sclk = flash_sclk;
        prev_cs = flash_cs_n;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    task automatic pulse_exit();
        @(negedge clk);
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
    endtask

    // one read: checks R2..R9 and R11 against the bench's own model of the flag
    task automatic do_read(input logic [23:0] addr, input logic [31:0] data,
                           input bit exit_pending);
        bit          exp_cmd = !exp_cont;
        logic [7:0]  exp_mode = exit_pending ? 8'hFF : 8'h20;
        int          nclk = exp_cmd ? 28 : 20;
        int          base = exp_cmd ? 8 : 0;
        int          cyc = 0;
        logic [7:0]  op = '0;
        logic [23:0] a = '0;
        logic [7:0]  m;
        bit          oe_ok = 1'b1;
        flash_word = data;
        data_start = base + 12;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11", "ready while busy", {31'd0, req_ready}, 32'd0);
        while (!rsp_valid && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == nclk * CLK_DIV, "R9", "response latency", cyc, nclk * CLK_DIV);
        chk(rsp_data == data, "R8", "read word", rsp_data, data);
        chk(rc == nclk, exp_cmd ? "R6" : "R5", "serial clocks", rc, nclk);
        if (exp_cmd) begin
            for (int i = 0; i < 8; i++) begin
                op = {op[6:0], cap_o[i][0]};
                if (cap_oe[i] != 4'b0001) oe_ok = 1'b0;
            end
            chk(op == 8'hEB, "R2", "opcode", op, 8'hEB);
            chk(oe_ok, "R2", "opcode lane enable", 0, 1);
        end
        oe_ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            a = {a[19:0], cap_o[base + i]};
            if (cap_oe[base + i] != 4'b1111) oe_ok = 1'b0;
        end
        chk(a == addr, "R3", "address", a, addr);
        chk(oe_ok, "R3", "address lane enable", 0, 1);
        m = {cap_o[base + 6], cap_o[base + 7]};
        chk(m == exp_mode, "R4", "mode byte", m, exp_mode);
        oe_ok = 1'b1;
        for (int i = base + 8; i < nclk; i++)
            if (cap_oe[i] != 4'b0000) oe_ok = 1'b0;
        chk(oe_ok, "R7", "released during dummy and data", 0, 1);
        chk(period_bad == 0, "R9", "serial clock period errors", period_bad, 0);
        exp_cont = (exp_mode[5:4] == 2'b10);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(flash_cs_n == 1'b1, "R1", "cs_n after reset", flash_cs_n, 1);
        chk(flash_sclk == 1'b0, "R1", "sclk after reset", flash_sclk, 0);
        chk(flash_io_oe == 4'b0, "R1", "oe after reset", flash_io_oe, 0);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    endtask

    task automatic t_enter_and_skip();
        do_read(24'h123456, 32'hDEADBEEF, 1'b0);  // R1: opcode sent first
        do_read(24'hABCDEF, 32'h0F1E2D3C, 1'b0);  // R5: opcode skipped
    endtask

    task automatic t_exit_then_opcode();
        pulse_exit();
        do_read(24'h000010, 32'h89ABCDEF, 1'b1);  // R6: FFh, no opcode yet
        do_read(24'hFFFFFC, 32'h13579BDF, 1'b0);  // R6: opcode is back
    endtask

    task automatic t_back_to_back();
        do_read(24'h5A5A5A, 32'h00000000, 1'b0);
        do_read(24'hA5A5A4, 32'hFFFFFFFF, 1'b0);
        chk(last_gap >= CLK_DIV, "R10", "deselect time", last_gap, CLK_DIV);
    endtask

    task automatic t_exit_while_clear();
        pulse_exit();
        do_read(24'h000000, 32'h2468ACE0, 1'b1);  // flag already set: no opcode, FFh
        pulse_exit();
        do_read(24'h3C3C3C, 32'hC0FFEE11, 1'b1);  // flag clear: opcode, FFh
        do_read(24'h765432, 32'h7E57DA7A, 1'b0);  // opcode again, keeps 20h
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enter_and_skip();
        t_exit_then_opcode();
        t_back_to_back();
        t_exit_while_clear();
        repeat (10) @(negedge clk);
        report();
        $finish;
    end
endmodule